// File: doc/BRIEF.md
# Timer Channel Count Clock and Clear Control

This block is one channel of a general-purpose timer. It holds an 8-bit control register, which software loads through a write strobe and a data byte. The register sets three things. The first is the source that advances the 16-bit up-counter: the system clock divided by 1, 2, 4 or 8, or edges on an external clock pin. The second is which edge of that pin is counted. The third is which event clears the counter: one of four general-register match or capture strobes, or a clear coming from the other channel of a two-channel timer.

The channel drives out its counter value and a clear strobe that goes to the other channel. The strobe is combinational, so two channels set for synchronous clearing zero their counters on the same clock edge. The compare and capture logic sits outside this block and delivers its results as the strobes `gr_evt`. The enable for synchronous operation is a single input bit, `sync_en`.

Top module: `tcc_chan`

## Requirements
- R1: Reset is asynchronous and active low. It sets the counter to 0, the control register to 0 and `clr_out` to 0. With the control register at 0, the counter then advances on every clock.
- R2: The clock-select field is control bits 2:0. When bit 2 is 0, codes 000/001/010/011 advance the counter once every 1/2/4/8 clocks. A free-running phase counter is cleared by reset and steps once per clock. With code n, the counter advances on the edges where the number of edges since reset, modulo 2^n, equals 2^n-1.
- R3: Any clock-select code with bit 2 set counts edges of `ext_clk`, and the internal divider then has no effect. The pin passes through two synchronizing flops. A pin level first sampled at clock edge k moves the counter at edge k+2.
- R4: The edge-select field is control bits 4:3. Code 00 counts rising edges of the pin and 01 counts falling edges. Codes 10 and 11 count both. Each detected edge advances the counter by exactly one.
- R5: The clear-select field is control bits 7:5. Codes 001, 010, 101 and 110 clear the counter at the next clock edge when `gr_evt` bit 0, 1, 2 or 3 (registers A, B, C, D) is high.
- R6: With clear-select code 000 or 100, no `gr_evt` pattern and no `peer_clr_in` clears the counter.
- R7: Clear-select codes 011 and 111 clear the counter when `peer_clr_in` is high while `sync_en` is 1. While `sync_en` is 0 those codes never clear, and `gr_evt` has no effect under either code.
- R8: When a clear and a count fall in the same cycle, the counter becomes 0.
- R9: The counter wraps from 0xFFFF to 0x0000 on a count.
- R10: `clr_out` is high in exactly those cycles in which the selected `gr_evt` bit (R5) clears this channel. A clear caused by `peer_clr_in` does not raise `clr_out`.
- R11: When `wr_en` is high at a clock edge, `wr_data` is loaded into the control register. The new setting governs the counter from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| ext_clk | input | 1 | External count clock pin, asynchronous |
| gr_evt | input | 4 | Match/capture strobes of registers A..D (bit 0 = A) |
| sync_en | input | 1 | Synchronous operation enable from the mode setting |
| peer_clr_in | input | 1 | Clear strobe from the other channel |
| count_o | output | 16 | Counter value |
| clr_out | output | 1 | Clear strobe to the other channel |

## Verification
Most faults in the prescaler phase, the synchronizer depth or the clear decode appear on `count_o` within eight clocks. Examples are a divider tick one cycle early, a synchronizer with one flop too many or too few, and a swapped event index. Each of these shifts the cycle in which the counter steps or returns to zero. A fault in the combinational strobe appears on `clr_out` in the same cycle as the event. The bench compares both outputs every cycle against a behavioural model, so each fault is reported at the first cycle where its effect reaches the outputs. The test includes a run through the 16-bit wrap.

// File: rtl/tcc_pkg.sv
`timescale 1ns/1ps
package tcc_pkg;

  localparam int CTL_W     = 8;
  localparam int DIV_SEL_W = 2;
  localparam int N_EVT     = 4;
  localparam int EVT_IDX_W = $clog2(N_EVT);

  // Control register layout, most significant field first.
  typedef struct packed {
    logic [2:0] clr_sel;
    logic [1:0] edge_sel;
    logic [2:0] clk_sel;
  } tcc_ctl_t;

  // Pick the count pulse for the programmed edge mode.
  function automatic logic edge_pick(input logic [1:0] mode,
                                     input logic rise, input logic fall);
    if (mode[1]) return rise | fall;
    return mode[0] ? fall : rise;
  endfunction

  // 1 when the clear-select code names a general-register event.
  function automatic logic sel_is_event(input logic [2:0] code);
    return (code[1:0] == 2'b01) || (code[1:0] == 2'b10);
  endfunction

  // 1 when the clear-select code asks for the cross-channel clear.
  function automatic logic sel_is_sync(input logic [2:0] code);
    return code[1:0] == 2'b11;
  endfunction

  // Event index: bit 2 picks the pair (A,B) or (C,D), bit 1 the member.
  function automatic logic [EVT_IDX_W-1:0] sel_event_idx(input logic [2:0] code);
    return {code[2], code[1]};
  endfunction

endpackage

// File: rtl/tcc_prescaler.sv
`timescale 1ns/1ps
module tcc_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick_o
);
  localparam int N_DIV = 1 << SEL_W;
  localparam int PRE_W = N_DIV - 1;

  logic [PRE_W-1:0] phase_q;
  logic [N_DIV-1:0] tick_v;

  // The tick for divide-by-2^n fires when the low n phase bits are all ones.
  function automatic logic low_bits_set(input logic [PRE_W-1:0] v, input int n);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < PRE_W; b++)
      if (b < n && !v[b]) ok = 1'b0;
    return ok;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + 1'b1;
  end

  for (genvar g = 0; g < N_DIV; g++) begin : g_tick
    assign tick_v[g] = low_bits_set(phase_q, g);
    if (g > 0) begin : g_nest
      // R2: a slower rate only ticks where every faster rate ticks too.
      p_rate_nest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_v[g] |-> tick_v[g-1]);
      // R2: divided rates never tick on two consecutive cycles.
      p_rate_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_v[g] |=> !tick_v[g]);
    end
  end

  assign tick_o = tick_v[div_sel];

endmodule

// File: rtl/tcc_edge_sync.sv
`timescale 1ns/1ps
module tcc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       hit_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise;
  logic              fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise  = sync_q[STAGES-1] & ~prev_q;
  assign fall  = ~sync_q[STAGES-1] & prev_q;
  assign hit_o = tcc_pkg::edge_pick(edge_sel, rise, fall);

  // R4: a detected edge yields a single-cycle pulse.
  p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  p_fall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
  // R4: only a real edge of the synchronized level can produce a count.
  p_hit_has_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (sync_q[STAGES-1] != prev_q));

endmodule

// File: rtl/tcc_clr_sel.sv
`timescale 1ns/1ps
module tcc_clr_sel
  import tcc_pkg::*;
(
  input  logic [2:0]       clr_sel,
  input  logic [N_EVT-1:0] gr_evt,
  input  logic             sync_en,
  input  logic             peer_clr,
  output logic             own_clr,
  output logic             sync_clr,
  output logic             clr_now
);
  logic [EVT_IDX_W-1:0] idx;

  assign idx      = sel_event_idx(clr_sel);
  assign own_clr  = sel_is_event(clr_sel) & gr_evt[idx];
  assign sync_clr = sel_is_sync(clr_sel) & sync_en & peer_clr;
  assign clr_now  = own_clr | sync_clr;

endmodule

// File: rtl/tcc_chan.sv
`timescale 1ns/1ps
module tcc_chan
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             ext_clk,
  input  logic [N_EVT-1:0] gr_evt,
  input  logic             sync_en,
  input  logic             peer_clr_in,
  output logic [CNT_W-1:0] count_o,
  output logic             clr_out
);
  tcc_ctl_t         ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             int_tick;
  logic             ext_hit;
  logic             cnt_en;
  logic             own_clr;
  logic             sync_clr;
  logic             clr_now;

  // Control register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= tcc_ctl_t'(wr_data);
  end

  tcc_prescaler #(.SEL_W(DIV_SEL_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (ctl_q.clk_sel[DIV_SEL_W-1:0]),
    .tick_o  (int_tick)
  );

  tcc_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ext_clk),
    .edge_sel (ctl_q.edge_sel),
    .hit_o    (ext_hit)
  );

  tcc_clr_sel u_clr (
    .clr_sel  (ctl_q.clr_sel),
    .gr_evt   (gr_evt),
    .sync_en  (sync_en),
    .peer_clr (peer_clr_in),
    .own_clr  (own_clr),
    .sync_clr (sync_clr),
    .clr_now  (clr_now)
  );

  assign cnt_en = ctl_q.clk_sel[2] ? ext_hit : int_tick;

  // Up-counter: clear beats count, natural wrap at the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_now) cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
  assign clr_out = own_clr;

  // R5 / R8: any selected clear leaves the counter at zero.
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (cnt_q == '0));
  // R2 / R3: without enable or clear the counter holds.
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_now && !cnt_en) |=> $stable(cnt_q));
  // R9: a count moves the counter by one, modulo 2^CNT_W.
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_now && cnt_en) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R10: the outgoing strobe only accompanies a real clear of this channel.
  p_strobe_own_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_out |-> clr_now);
  // R7: a peer clear without synchronous operation does nothing.
  p_sync_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en && ctl_q.clr_sel[1:0] == 2'b11) |-> !clr_now);
  // R11: a write lands in the control register at the next edge.
  p_ctl_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q == tcc_ctl_t'($past(wr_data))));

endmodule

// File: tb/tcc_chan_tb.sv
`timescale 1ns/1ps
module tcc_chan_tb;
  localparam real CLK_NS   = 4.0;
  localparam int  WATCHDOG = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        ext_clk = 1'b0;
  logic [3:0]  gr_evt = 4'h0;
  logic        sync_en = 1'b0;
  logic        peer_clr_in = 1'b0;
  logic [15:0] count_o;
  logic        clr_out;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #(CLK_NS/2) clk = ~clk;

  tcc_chan u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ext_clk(ext_clk), .gr_evt(gr_evt), .sync_en(sync_en),
    .peer_clr_in(peer_clr_in), .count_o(count_o), .clr_out(clr_out)
  );

  // ---------------- reference model ----------------
  int       m_cnt;
  int       m_cyc;
  bit [7:0] m_ctl;
  bit       pin_hist[$];

  function automatic bit exp_own(bit [7:0] c, bit [3:0] e);
    case (c[7:5])
      3'b001:  return e[0];
      3'b010:  return e[1];
      3'b101:  return e[2];
      3'b110:  return e[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit exp_sync(bit [7:0] c, bit en, bit peer);
    return (c[6:5] == 2'b11) && en && peer;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cyc = 0; m_ctl = 8'h00;
      pin_hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      bit en;
      bit clr;
      if (m_ctl[2]) begin
        bit cur;
        bit old;
        cur = pin_hist[1];
        old = pin_hist[2];
        if (m_ctl[4])      en = (cur != old);
        else if (m_ctl[3]) en = (!cur && old);
        else               en = (cur && !old);
      end else begin
        int rate;
        rate = 1 << m_ctl[1:0];
        en = ((m_cyc % rate) == rate - 1);
      end
      clr = exp_own(m_ctl, gr_evt) || exp_sync(m_ctl, sync_en, peer_clr_in);
      if (clr)     m_cnt = 0;
      else if (en) m_cnt = (m_cnt + 1) % 65536;
      pin_hist.push_front(ext_clk);
      void'(pin_hist.pop_back());
      m_cyc++;
      if (wr_en) m_ctl = wr_data;
    end
  end

  // ---------------- comparison every cycle ----------------
  always @(negedge clk) begin
    #1;
    if (!done) begin
      bit ec;
      ec = exp_own(m_ctl, gr_evt);
      checks++;
      if (count_o !== 16'(m_cnt)) begin
        errors++;
        $display("FAIL %s count: actual %0h expected %0h at %0t", cur_req, count_o, m_cnt, $time);
      end
      checks++;
      if (clr_out !== ec) begin
        errors++;
        $display("FAIL %s clr_out: actual %0b expected %0b at %0t", cur_req, clr_out, ec, $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic write_ctl(input bit [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // mode bits: 0 toggle pin randomly, 1 random events, 2 random peer clears
  task automatic run(input int n, input bit [2:0] mode, input int evt_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mode[0] && ($urandom % 3 == 0)) ext_clk = ~ext_clk;
      for (int b = 0; b < 4; b++)
        gr_evt[b] = mode[1] && (($urandom % 100) < evt_pct);
      peer_clr_in = mode[2] && ($urandom % 6 == 0);
    end
    @(negedge clk);
    gr_evt = 4'h0; peer_clr_in = 1'b0;
  endtask

  task automatic check_now(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check_now("R1 reset count", count_o == 16'h0, count_o, 0);
    check_now("R1 reset strobe", clr_out == 1'b0, clr_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    run(10, 3'b000, 0);
    check_now("R1 counts every clock", count_o != 16'h0, count_o, m_cnt);

    // R2, R11: internal division codes
    cur_req = "R2";
    for (int c = 1; c < 4; c++) begin
      write_ctl(8'(c));
      run(29, 3'b001, 0);    // pin activity must not matter here
    end
    cur_req = "R11";
    write_ctl(8'h02); write_ctl(8'h00); write_ctl(8'h03);
    run(5, 3'b000, 0);

    // R9: wrap at 0xFFFF with divide-by-1
    cur_req = "R9";
    write_ctl(8'h00);
    run(65560, 3'b000, 0);
    check_now("R9 wrapped to a small value", count_o < 16'd200, count_o, m_cnt);

    // R3, R4: external clock with each edge mode
    cur_req = "R3";
    write_ctl(8'h04); run(60, 3'b001, 0);
    write_ctl(8'h07); run(60, 3'b001, 0);
    cur_req = "R4";
    write_ctl(8'h0C); run(60, 3'b001, 0);
    write_ctl(8'h14); run(60, 3'b001, 0);
    write_ctl(8'h1D); run(60, 3'b001, 0);

    // R5, R8, R10: event clears at divide-by-1 and divide-by-4
    cur_req = "R5";
    write_ctl(8'h20); run(50, 3'b010, 10);
    write_ctl(8'h40); run(50, 3'b010, 10);
    write_ctl(8'hA0); run(50, 3'b010, 10);
    write_ctl(8'hC0); run(50, 3'b010, 10);
    cur_req = "R8";
    write_ctl(8'h22); run(60, 3'b010, 15);
    write_ctl(8'hDC); run(80, 3'b011, 15);
    cur_req = "R10";
    write_ctl(8'hA1); run(60, 3'b110, 20);

    // R6: no-clear codes under heavy events and peer clears
    cur_req = "R6";
    sync_en = 1'b1;
    write_ctl(8'h00); run(40, 3'b110, 50);
    write_ctl(8'h80); run(40, 3'b110, 50);

    // R7: synchronous clear with and without the enable
    cur_req = "R7";
    write_ctl(8'h60); run(60, 3'b110, 30);
    write_ctl(8'hE1); run(60, 3'b110, 30);
    sync_en = 1'b0;
    write_ctl(8'h60); run(60, 3'b110, 30);
    write_ctl(8'hE0); run(60, 3'b110, 30);

    @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * WATCHDOG);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule